// File: doc/BRIEF.md
# Quadratic Permutation Interleaver Address Generator

This block produces the read or write address sequence of a quadratic permutation polynomial interleaver. The sequence is P(i) = (f1*i + f2*i^2) mod N for i = 0 to N-1, at one address per clock. A turbo decoder datapath uses it to visit a frame buffer in permuted order. The frame length N and the coefficients f1 and f2 change from one block to the next. They are supplied on input ports and captured on a single-cycle start pulse.

The block contains no multiplier and no divider. It keeps a running address and a running increment. Each step adds the increment to the address, then grows the increment by a precomputed constant 2*f2 mod N. Every sum is reduced by at most one subtraction of N, because both operands are already smaller than N. The two modular adders that do this work are shared with the start-up step. At start they form (f1+f2) mod N and (2*f2) mod N.

Top module: `qpp_addr_gen`

## Requirements
- R1: While reset is high and after reset, until the first start, `out_valid` and `out_last` are 0 and `out_addr` and `out_idx` are 0.
- R2: In the cycle after a cycle with `start` high, `out_valid` is 1, `out_idx` is 0 and `out_addr` is 0. `frame_len`, `coef_lin` and `coef_quad` are sampled only in the start cycle, and changes to them in later cycles do not alter the sequence.
- R3: While `out_valid` is 1 and `out_last` is 0, the next cycle shows `out_idx` one higher than before, with `out_valid` still 1.
- R4: Whenever `out_valid` is 1, `out_addr` equals (f1*i + f2*i^2) mod N for i = `out_idx`, using the captured N, f1 and f2, and `out_addr` is below N.
- R5: `out_last` is 1 exactly in the cycle where `out_valid` is 1 and `out_idx` equals N-1.
- R6: In the cycle after `out_last`, `out_valid` and `out_last` are 0. `out_addr` and `out_idx` then hold their final values until the next start.
- R7: A start pulse while a sequence is running abandons it. The next cycle begins the new sequence as in R2.
- R8: Results are exact for N from 2 to 2^AW-1 (8191 by default) with f1 and f2 below N, including f1 = f2 = N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that loads the parameters and begins a sequence |
| frame_len | input | AW | Block length N, sampled at start |
| coef_lin | input | AW | Linear coefficient f1, sampled at start, below N |
| coef_quad | input | AW | Quadratic coefficient f2, sampled at start, below N |
| out_addr | output | AW | Interleaved address P(i) |
| out_idx | output | AW | Index i of the current address |
| out_valid | output | 1 | High while a sequence is being emitted |
| out_last | output | 1 | High with the final address, i = N-1 |

## Verification
The assertions take for granted that every start carries N of at least 2 and coefficients strictly below N. Outside that range the single-subtraction reduction and the end-of-sequence compare are not defined. The stimulus draws N from a bounded range of at least 40, or uses directed values of at least 2. It draws f1 and f2 as a random value modulo N, and directed extremes use N-1. Between start pulses the parameter inputs receive arbitrary values, including values outside that range, because only the start cycle samples them.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

  // Run state of the sequencer
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Number of shared modular adders in the recursion datapath
  localparam int unsigned NUM_ADDERS = 2;

endpackage

// File: rtl/qpp_mod_add.sv
// Modular adder: (a + b) mod n, assuming a < n and b < n.
module qpp_mod_add #(
  parameter int unsigned AW = 13
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic [AW-1:0] n,
  output logic [AW-1:0] sum_mod
);

  localparam int unsigned SW = AW + 1;

  logic [SW-1:0] raw_sum;
  logic [SW-1:0] reduced;
  logic          wrap;

  always_comb begin
    raw_sum = {1'b0, a} + {1'b0, b};
    reduced = raw_sum - {1'b0, n};
    wrap    = (raw_sum >= {1'b0, n});
    sum_mod = wrap ? reduced[AW-1:0] : raw_sum[AW-1:0];
  end

endmodule

// File: rtl/qpp_seq_ctrl.sv
// Index counter, run state and end-of-block detection.
module qpp_seq_ctrl
  import qpp_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] frame_len,
  output logic [AW-1:0] n_cur,
  output logic [AW-1:0] idx,
  output logic          running,
  output logic          last,
  output logic          advance
);

  localparam logic [AW-1:0] ONE = AW'(1);

  seq_state_e    state_q;
  logic [AW-1:0] n_q;
  logic [AW-1:0] idx_q;
  logic          last_q;
  logic [AW-1:0] idx_inc;
  logic [AW-1:0] final_idx;

  always_comb begin
    idx_inc   = idx_q + ONE;
    final_idx = n_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      n_q     <= '0;
      idx_q   <= '0;
      last_q  <= 1'b0;
    end else if (start) begin
      state_q <= SEQ_RUN;
      n_q     <= frame_len;
      idx_q   <= '0;
      last_q  <= 1'b0;
    end else if (state_q == SEQ_RUN) begin
      if (last_q) begin
        state_q <= SEQ_IDLE;
        last_q  <= 1'b0;
      end else begin
        idx_q  <= idx_inc;
        last_q <= (idx_inc == final_idx);
      end
    end
  end

  assign n_cur   = n_q;
  assign idx     = idx_q;
  assign running = (state_q == SEQ_RUN);
  assign last    = last_q;
  assign advance = (state_q == SEQ_RUN) && !last_q;

endmodule

// File: rtl/qpp_recur.sv
// Address recursion: P(i+1) = P(i) + g(i), g(i+1) = g(i) + 2*f2, all mod N.
// The two modular adders are shared between the start-up and the step.
module qpp_recur
  import qpp_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          advance,
  input  logic [AW-1:0] frame_len,
  input  logic [AW-1:0] coef_lin,
  input  logic [AW-1:0] coef_quad,
  input  logic [AW-1:0] n_cur,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] incr_q;
  logic [AW-1:0] dstep_q;

  logic [AW-1:0] op_a   [NUM_ADDERS];
  logic [AW-1:0] op_b   [NUM_ADDERS];
  logic [AW-1:0] op_n   [NUM_ADDERS];
  logic [AW-1:0] result [NUM_ADDERS];

  // Operand selection: adder 0 forms f1+f2 or P+g, adder 1 forms 2*f2 or g+2*f2
  always_comb begin
    if (start) begin
      op_a[0] = coef_lin;
      op_b[0] = coef_quad;
      op_a[1] = coef_quad;
      op_b[1] = coef_quad;
    end else begin
      op_a[0] = addr_q;
      op_b[0] = incr_q;
      op_a[1] = incr_q;
      op_b[1] = dstep_q;
    end
  end

  for (genvar k = 0; k < NUM_ADDERS; k++) begin : g_adders
    assign op_n[k] = start ? frame_len : n_cur;
    qpp_mod_add #(.AW(AW)) add_i (
      .a       (op_a[k]),
      .b       (op_b[k]),
      .n       (op_n[k]),
      .sum_mod (result[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      incr_q  <= '0;
      dstep_q <= '0;
    end else if (start) begin
      addr_q  <= '0;
      incr_q  <= result[0];
      dstep_q <= result[1];
    end else if (advance) begin
      addr_q <= result[0];
      incr_q <= result[1];
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
  import qpp_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] frame_len,
  input  logic [AW-1:0] coef_lin,
  input  logic [AW-1:0] coef_quad,
  output logic [AW-1:0] out_addr,
  output logic [AW-1:0] out_idx,
  output logic          out_valid,
  output logic          out_last
);

  logic [AW-1:0] n_cur;
  logic          advance;

  qpp_seq_ctrl #(.AW(AW)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .frame_len (frame_len),
    .n_cur     (n_cur),
    .idx       (out_idx),
    .running   (out_valid),
    .last      (out_last),
    .advance   (advance)
  );

  qpp_recur #(.AW(AW)) recur_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .advance   (advance),
    .frame_len (frame_len),
    .coef_lin  (coef_lin),
    .coef_quad (coef_quad),
    .n_cur     (n_cur),
    .addr      (out_addr)
  );

endmodule

// File: rtl/qpp_addr_gen_checker.sv
module qpp_addr_gen_checker #(
  parameter int unsigned AW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [AW-1:0] out_addr,
  input logic [AW-1:0] out_idx,
  input logic          out_valid,
  input logic          out_last,
  input logic [AW-1:0] n_cur
);

  // R2, R7: a start always yields index 0, address 0 next cycle
  a_r2_start_zero: assert property (@(posedge clk) disable iff (rst)
    start |=> (out_valid && out_idx == '0 && out_addr == '0));

  // R3: index steps by one while the sequence continues
  a_r3_idx_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last && !start) |=>
      (out_valid && out_idx == $past(out_idx) + AW'(1)));

  // R4: address stays inside the frame
  a_r4_addr_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_addr < n_cur));

  // R5: last coincides with the final index
  a_r5_last_idx: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_valid && out_idx == n_cur - AW'(1)));

  // R6: sequence stops after last and outputs hold while idle
  a_r6_stop_after_last: assert property (@(posedge clk) disable iff (rst)
    (out_last && !start) |=> (!out_valid && !out_last));

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !start) |=> ($stable(out_addr) && $stable(out_idx)));

  // R1: last never raised without valid
  a_r1_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

endmodule

bind qpp_addr_gen qpp_addr_gen_checker #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .out_addr  (out_addr),
  .out_idx   (out_idx),
  .out_valid (out_valid),
  .out_last  (out_last),
  .n_cur     (n_cur)
);

// File: tb/qpp_addr_gen_tb_top.sv
`timescale 1ns/1ps
module qpp_addr_gen_tb_top;

  localparam int unsigned AW = 13;
  localparam int WATCHDOG_CYCLES = 190000;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [AW-1:0] frame_len;
  logic [AW-1:0] coef_lin;
  logic [AW-1:0] coef_quad;
  logic [AW-1:0] out_addr;
  logic [AW-1:0] out_idx;
  logic          out_valid;
  logic          out_last;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  qpp_addr_gen #(.AW(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .frame_len (frame_len),
    .coef_lin  (coef_lin),
    .coef_quad (coef_quad),
    .out_addr  (out_addr),
    .out_idx   (out_idx),
    .out_valid (out_valid),
    .out_last  (out_last)
  );

  function automatic int qpp_ref(int n, int f1, int f2, int i);
    longint v;
    v = longint'(f1) * i + longint'(f2) * i * i;
    return int'(v % n);
  endfunction

  task automatic check_out(string req, bit ev, bit el, int ei, int ea);
    checks++;
    if (out_valid !== ev || out_last !== el || int'(out_idx) != ei || int'(out_addr) != ea) begin
      errors++;
      $display("FAIL %s: got valid=%0b last=%0b idx=%0d addr=%0d, expected valid=%0b last=%0b idx=%0d addr=%0d",
               req, out_valid, out_last, out_idx, out_addr, ev, el, ei, ea);
    end
  endtask

  // Runs one sequence; stop_after > 0 abandons it after that many outputs (R7)
  task automatic run_block(int n, int f1, int f2, int stop_after);
    @(negedge clk);
    frame_len = AW'(n);
    coef_lin  = AW'(f1);
    coef_quad = AW'(f2);
    start     = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
      // R2: parameter inputs are ignored after the start cycle
      frame_len = AW'($urandom);
      coef_lin  = AW'($urandom);
      coef_quad = AW'($urandom);
      check_out((i == 0) ? "R2/R4" : ((i == n-1) ? "R5/R4" : "R3/R4"),
                1'b1, (i == n-1), i, qpp_ref(n, f1, f2, i));
      if (stop_after > 0 && i + 1 == stop_after) return;
    end
    @(negedge clk);
    check_out("R6 stop", 1'b0, 1'b0, n-1, qpp_ref(n, f1, f2, n-1));
    @(negedge clk);
    check_out("R6 hold", 1'b0, 1'b0, n-1, qpp_ref(n, f1, f2, n-1));
  endtask

  initial begin
    int n;
    void'($urandom(32'd4711));
    rst = 1'b1; start = 1'b0;
    frame_len = '0; coef_lin = '0; coef_quad = '0;
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 1'b0, 1'b0, 0, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_out("R1 after reset", 1'b0, 1'b0, 0, 0);

    // Directed corner cases
    run_block(40, 3, 10, 0);
    run_block(2, 1, 1, 0);              // R5: shortest frame
    run_block(6144, 263, 480, 0);
    run_block(6144, 6143, 6143, 0);     // R8: operand extremes
    run_block(8191, 8190, 8190, 0);     // R8: widest frame
    run_block(3, 0, 0, 0);              // R4: all-zero sequence
    // R7: restart mid-sequence
    run_block(1000, 17, 300, 25);
    run_block(512, 31, 64, 1);
    run_block(104, 7, 26, 0);

    // Constrained random frames
    for (int k = 0; k < 6; k++) begin
      n = 40 + int'($urandom % 2961);
      run_block(n, int'($urandom % n), int'($urandom % n), 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion within %0d cycles", WATCHDOG_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule